// File: doc/BRIEF.md
# DMA Trigger Capture and Channel Arbiter

This block gathers transfer trigger events for a bank of ordinary DMA channels (64 by default) and a smaller bank of quick-DMA (QDMA) channels (8 by default). Each recognised trigger sets a sticky pending bit. The block then nominates one pending channel at a time to the event-queue stage that follows it. The nomination carries a channel number, a flag that tells a QDMA channel from a DMA channel, and the index of the queue that the channel is mapped to.

A DMA channel has three trigger sources. The first is a one-cycle pulse on its external event line, which is gated by a per-channel enable bit. The second is a software write that sets event bits. The third is a chain pulse from completion logic. A QDMA channel is triggered by a one-cycle strobe, which stands for software writing that channel's trigger word. Software reaches the enable bits and the event-set bits through a 32-bit write port, with one address for the low half of the 64 channels and another for the high half.

Any DMA channel wins over any QDMA channel. Inside each group, the lowest channel number wins. A channel is offered only while its mapped queue reports ready. A channel stuck behind a full queue therefore stays pending, and lower-priority channels that map to other queues can go ahead of it. The handshake completes in any cycle in which `out_valid` is high, and the pending bit of the offered channel clears at that clock edge.

Top module: `dma_evt_arb`

## Requirements
- R1: A synchronous active-high reset clears all pending bits and all enable bits, and `out_valid` is low on the first cycle after reset.
- R2: A pulse on `ext_evt[c]` makes DMA channel c pending only while its enable bit is set. Writing ones to address 0 (channels 0..31) or address 1 (channels 32..63) sets enable bits. Writing ones to address 2 (low half) or address 3 (high half) clears them.
- R3: Writing ones to address 4 (channels 0..31) or address 5 (channels 32..63) makes the addressed DMA channels pending, whatever their enable bits hold.
- R4: A pulse on `chain_evt[c]` makes DMA channel c pending, whatever its enable bit holds.
- R5: A pulse on `qdma_trig[k]` makes QDMA channel k pending. It is offered with `out_is_qdma` = 1 and `out_chan` = k.
- R6: While any DMA channel is pending on a ready queue, no QDMA channel is offered.
- R7: Within the DMA group and within the QDMA group, the lowest-numbered eligible channel is offered.
- R8: A pending bit holds until its channel is offered with `out_valid` high, and it clears at that clock edge. Each channel is offered once per trigger.
- R9: A trigger for a channel that arrives at the clock edge where that channel is accepted leaves the channel pending, so it is offered again.
- R10: A channel whose mapped queue has `q_ready` low is skipped. A lower-priority channel on a ready queue is offered in its place, and the skipped channel is offered once its queue is ready again.
- R11: `out_valid` high implies that `q_ready[out_queue]` is high, and `out_queue` equals the queue map entry of the offered channel.
- R12: Writes to address codes 6 and 7 change neither the pending bits nor the enable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_evt | input | 64 | External event pulses, one per DMA channel |
| chain_evt | input | 64 | Chain trigger pulses from completion logic |
| qdma_trig | input | 8 | Trigger-word write strobes, one per QDMA channel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: {function[1:0], half} |
| wr_data | input | 32 | Write data, one bit per channel of the addressed half |
| dma_qmap | input | 64 | Queue index per DMA channel, 1 bit each |
| qdma_qmap | input | 8 | Queue index per QDMA channel, 1 bit each |
| q_ready | input | 2 | Per-queue space available |
| out_valid | output | 1 | A channel is offered this cycle; it is accepted at the next edge |
| out_is_qdma | output | 1 | Offered channel is a QDMA channel |
| out_chan | output | 6 | Offered channel number |
| out_queue | output | 1 | Queue that the offered channel maps to |

## Verification
A trigger or write that is captured at a clock edge shows up on the outputs right after that same edge, because the offer is decoded combinationally from the pending registers. The bench therefore drives inputs on the falling edge and checks the offer on the next falling edge. A pending bit clears at the edge that accepts it, so the next channel in priority order appears one edge later, and the bench checks one channel for each clock of a drain sequence. A change of `q_ready` acts inside the same cycle, so the bench samples shortly after driving it and before the next rising edge.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;

  // Function field (upper two address bits) of the register write port.
  typedef enum logic [1:0] {
    FN_EN_SET  = 2'd0,
    FN_EN_CLR  = 2'd1,
    FN_EVT_SET = 2'd2,
    FN_RSVD    = 2'd3
  } wr_func_e;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/evt_wr_decode.sv
module evt_wr_decode
  import dma_evt_pkg::*;
#(
  parameter int N     = 64,
  parameter int REG_W = 32,
  localparam int NWORD = (N + REG_W - 1) / REG_W,
  localparam int WW    = idx_w(NWORD),
  localparam int AW    = WW + 2
) (
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [REG_W-1:0] wr_data,
  output logic [N-1:0]     en_set,
  output logic [N-1:0]     en_clr,
  output logic [N-1:0]     evt_set
);

  wr_func_e               fn;
  logic [NWORD*REG_W-1:0] set_w, clr_w, evt_w;

  assign fn = wr_func_e'(wr_addr[AW-1 -: 2]);

  for (genvar w = 0; w < NWORD; w++) begin : g_word
    logic hit;
    assign hit = wr_en && (wr_addr[WW-1:0] == WW'(w));
    assign set_w[w*REG_W +: REG_W] = (hit && fn == FN_EN_SET)  ? wr_data : '0;
    assign clr_w[w*REG_W +: REG_W] = (hit && fn == FN_EN_CLR)  ? wr_data : '0;
    assign evt_w[w*REG_W +: REG_W] = (hit && fn == FN_EVT_SET) ? wr_data : '0;
  end

  assign en_set  = set_w[N-1:0];
  assign en_clr  = clr_w[N-1:0];
  assign evt_set = evt_w[N-1:0];

endmodule

// File: rtl/evt_sticky_bank.sv
module evt_sticky_bank #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] q
);

  // A set in the same cycle as a clear leaves the bit set.
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~clr_vec) | set_vec;
  end

endmodule

// File: rtl/low_first_enc.sv
module low_first_enc
  import dma_evt_pkg::*;
#(
  parameter int N  = 64,
  localparam int IW = idx_w(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);

  // Scan from the top so the lowest set index is written last and wins.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

endmodule

// File: rtl/dma_evt_arb.sv
module dma_evt_arb
  import dma_evt_pkg::*;
#(
  parameter int N_DMA   = 64,
  parameter int N_QDMA  = 8,
  parameter int N_QUEUE = 2,
  parameter int REG_W   = 32,
  localparam int QW   = idx_w(N_QUEUE),
  localparam int DW   = idx_w(N_DMA),
  localparam int KW   = idx_w(N_QDMA),
  localparam int CW   = (DW > KW) ? DW : KW,
  localparam int NWRD = (N_DMA + REG_W - 1) / REG_W,
  localparam int AW   = idx_w(NWRD) + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_DMA-1:0]     ext_evt,
  input  logic [N_DMA-1:0]     chain_evt,
  input  logic [N_QDMA-1:0]    qdma_trig,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [REG_W-1:0]     wr_data,
  input  logic [N_DMA*QW-1:0]  dma_qmap,
  input  logic [N_QDMA*QW-1:0] qdma_qmap,
  input  logic [N_QUEUE-1:0]   q_ready,
  output logic                 out_valid,
  output logic                 out_is_qdma,
  output logic [CW-1:0]        out_chan,
  output logic [QW-1:0]        out_queue
);

  logic [N_DMA-1:0]  en_set, en_clr, sw_set;
  logic [N_DMA-1:0]  dma_en, dma_pend, dma_set_vec, dma_clr_vec, dma_ok;
  logic [N_QDMA-1:0] qdma_pend, qdma_clr_vec, qdma_ok;
  logic              dma_found, qdma_found;
  logic [DW-1:0]     dma_idx;
  logic [KW-1:0]     qdma_idx;
  logic              take_dma, take_qdma;

  evt_wr_decode #(.N(N_DMA), .REG_W(REG_W)) u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .en_set  (en_set),
    .en_clr  (en_clr),
    .evt_set (sw_set)
  );

  evt_sticky_bank #(.N(N_DMA)) u_enable (
    .clk (clk), .rst (rst), .set_vec (en_set), .clr_vec (en_clr), .q (dma_en)
  );

  assign dma_set_vec = (ext_evt & dma_en) | sw_set | chain_evt;

  evt_sticky_bank #(.N(N_DMA)) u_dma_pend (
    .clk (clk), .rst (rst), .set_vec (dma_set_vec), .clr_vec (dma_clr_vec), .q (dma_pend)
  );

  evt_sticky_bank #(.N(N_QDMA)) u_qdma_pend (
    .clk (clk), .rst (rst), .set_vec (qdma_trig), .clr_vec (qdma_clr_vec), .q (qdma_pend)
  );

  // A channel is eligible only while the queue it maps to has space.
  for (genvar c = 0; c < N_DMA; c++) begin : g_dma_ok
    logic [QW-1:0] qi;
    assign qi        = dma_qmap[c*QW +: QW];
    assign dma_ok[c] = (32'(qi) < N_QUEUE) && q_ready[qi];
  end

  for (genvar k = 0; k < N_QDMA; k++) begin : g_qdma_ok
    logic [QW-1:0] qi;
    assign qi         = qdma_qmap[k*QW +: QW];
    assign qdma_ok[k] = (32'(qi) < N_QUEUE) && q_ready[qi];
  end

  low_first_enc #(.N(N_DMA)) u_dma_enc (
    .req (dma_pend & dma_ok), .found (dma_found), .idx (dma_idx)
  );

  low_first_enc #(.N(N_QDMA)) u_qdma_enc (
    .req (qdma_pend & qdma_ok), .found (qdma_found), .idx (qdma_idx)
  );

  assign take_dma  = dma_found;
  assign take_qdma = !dma_found && qdma_found;

  assign out_valid   = take_dma || take_qdma;
  assign out_is_qdma = take_qdma;

  always_comb begin
    out_chan  = '0;
    out_queue = '0;
    if (take_dma) begin
      out_chan  = CW'(dma_idx);
      out_queue = dma_qmap[dma_idx*QW +: QW];
    end else if (take_qdma) begin
      out_chan  = CW'(qdma_idx);
      out_queue = qdma_qmap[qdma_idx*QW +: QW];
    end
  end

  // Acceptance is implied by out_valid: eligibility already required space.
  always_comb begin
    dma_clr_vec  = '0;
    qdma_clr_vec = '0;
    if (take_dma)  dma_clr_vec[dma_idx]   = 1'b1;
    if (take_qdma) qdma_clr_vec[qdma_idx] = 1'b1;
  end

endmodule

// File: rtl/dma_evt_arb_chk.sv
module dma_evt_arb_chk #(
  parameter int N_DMA   = 64,
  parameter int N_QUEUE = 2,
  parameter int QW      = 1,
  parameter int CW      = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               out_valid,
  input logic               out_is_qdma,
  input logic [CW-1:0]      out_chan,
  input logic [QW-1:0]      out_queue,
  input logic [N_QUEUE-1:0] q_ready,
  input logic [N_DMA-1:0]   dma_pend,
  input logic [N_DMA-1:0]   dma_ok,
  input logic [N_DMA-1:0]   dma_set_vec
);

  logic [N_DMA-1:0] below_mask;
  always_comb below_mask = (N_DMA'(1) << out_chan) - N_DMA'(1);

  // R1
  rst_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  // R11
  ready_q_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> q_ready[out_queue]);

  // R6
  dma_first_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_is_qdma) |-> ((dma_pend & dma_ok) == '0));

  // R7
  lowest_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_is_qdma) |-> ((dma_pend & dma_ok & below_mask) == '0));

  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_set_vec != '0) |=> ((dma_pend & $past(dma_set_vec)) == $past(dma_set_vec)));

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_is_qdma && !dma_set_vec[out_chan]) |=> !dma_pend[$past(out_chan)]);

endmodule

bind dma_evt_arb dma_evt_arb_chk #(
  .N_DMA(N_DMA), .N_QUEUE(N_QUEUE), .QW(QW), .CW(CW)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .out_valid   (out_valid),
  .out_is_qdma (out_is_qdma),
  .out_chan    (out_chan),
  .out_queue   (out_queue),
  .q_ready     (q_ready),
  .dma_pend    (dma_pend),
  .dma_ok      (dma_ok),
  .dma_set_vec (dma_set_vec)
);

// File: tb/test_dma_evt_arb.sv
module test_dma_evt_arb;

  logic        clk = 1'b0;
  logic        rst;
  logic [63:0] ext_evt, chain_evt;
  logic [7:0]  qdma_trig;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic [63:0] dma_qmap;
  logic [7:0]  qdma_qmap;
  logic [1:0]  q_ready;
  logic        out_valid, out_is_qdma;
  logic [5:0]  out_chan;
  logic [0:0]  out_queue;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  dma_evt_arb i_dma_evt_arb (
    .clk, .rst, .ext_evt, .chain_evt, .qdma_trig, .wr_en, .wr_addr, .wr_data,
    .dma_qmap, .qdma_qmap, .q_ready, .out_valid, .out_is_qdma, .out_chan, .out_queue
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    ext_evt = '0; chain_evt = '0; qdma_trig = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Check the offer: valid, and when valid the type flag and channel.
  task automatic expect_sel(input string req, input bit v, input bit q, input int ch);
    check({req, " valid"}, int'(out_valid), int'(v));
    if (v) begin
      check({req, " qdma"}, int'(out_is_qdma), int'(q));
      check({req, " chan"}, int'(out_chan), ch);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    quiet();
  endtask

  task automatic t_reset();
    rst = 1'b1; quiet();
    dma_qmap = '0; qdma_qmap = '0; q_ready = 2'b11;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    expect_sel("R1 reset idle", 0, 0, 0);
    ext_evt = '1; tick(); quiet();
    expect_sel("R1 enables clear after reset", 0, 0, 0);
  endtask

  task automatic t_enable_gate();
    reg_write(3'd0, 32'h1 << 5);
    ext_evt[5] = 1'b1; tick(); quiet();
    expect_sel("R2 enabled ext event", 1, 0, 5);
    tick();
    expect_sel("R2 drained", 0, 0, 0);
    reg_write(3'd2, 32'h1 << 5);
    ext_evt[5] = 1'b1; tick(); quiet();
    expect_sel("R2 disabled ext event ignored", 0, 0, 0);
    reg_write(3'd1, 32'h1 << 2);
    ext_evt[34] = 1'b1; tick(); quiet();
    expect_sel("R2 high-half enable", 1, 0, 34);
    tick();
    reg_write(3'd3, 32'h1 << 2);
    ext_evt[34] = 1'b1; tick(); quiet();
    expect_sel("R2 high-half clear", 0, 0, 0);
  endtask

  task automatic t_manual();
    reg_write(3'd5, 32'h1 << 3);
    expect_sel("R3 manual set high half", 1, 0, 35);
    tick();
    reg_write(3'd4, 32'h1 << 17);
    expect_sel("R3 manual set low half", 1, 0, 17);
    tick();
    expect_sel("R3 drained", 0, 0, 0);
  endtask

  task automatic t_chain();
    chain_evt[60] = 1'b1; tick(); quiet();
    expect_sel("R4 chain trigger", 1, 0, 60);
    tick();
    expect_sel("R4 drained", 0, 0, 0);
  endtask

  task automatic t_qdma();
    qdma_trig[2] = 1'b1; tick(); quiet();
    expect_sel("R5 qdma strobe", 1, 1, 2);
    tick();
    expect_sel("R5 drained", 0, 0, 0);
  endtask

  task automatic t_priority();
    qdma_trig = 8'b1001_0000;
    qdma_trig[0] = 1'b1;
    chain_evt[40] = 1'b1; chain_evt[12] = 1'b1;
    wr_en = 1'b1; wr_addr = 3'd4; wr_data = 32'h1 << 9;
    tick(); quiet();
    expect_sel("R7 lowest dma first", 1, 0, 9);  tick();
    expect_sel("R7 next dma", 1, 0, 12);         tick();
    expect_sel("R6 dma before qdma", 1, 0, 40);  tick();
    expect_sel("R7 lowest qdma", 1, 1, 0);       tick();
    expect_sel("R7 qdma 4", 1, 1, 4);            tick();
    expect_sel("R7 qdma 7", 1, 1, 7);            tick();
    expect_sel("R8 each offered once", 0, 0, 0);
  endtask

  task automatic t_hold();
    q_ready = 2'b00;
    chain_evt[7] = 1'b1; tick(); quiet();
    for (int i = 0; i < 3; i++) begin
      expect_sel("R8 held while no space", 0, 0, 0);
      tick();
    end
    q_ready = 2'b11; #1;
    expect_sel("R8 still pending", 1, 0, 7);
    tick();
    expect_sel("R8 cleared on accept", 0, 0, 0);
  endtask

  task automatic t_same_cycle();
    chain_evt[20] = 1'b1; tick(); quiet();
    expect_sel("R9 first offer", 1, 0, 20);
    chain_evt[20] = 1'b1; tick(); quiet();
    expect_sel("R9 retrigger on accept kept", 1, 0, 20);
    tick();
    expect_sel("R9 drained", 0, 0, 0);
  endtask

  task automatic t_blocked();
    dma_qmap[3] = 1'b1; dma_qmap[10] = 1'b0;
    q_ready = 2'b01;
    chain_evt[3] = 1'b1; chain_evt[10] = 1'b1; tick(); quiet();
    expect_sel("R10 blocked channel bypassed", 1, 0, 10);
    check("R11 queue of ch10", int'(out_queue), 0);
    tick();
    expect_sel("R10 blocked waits", 0, 0, 0);
    q_ready = 2'b11; #1;
    expect_sel("R10 offered when space returns", 1, 0, 3);
    check("R11 queue of ch3", int'(out_queue), 1);
    tick();
    expect_sel("R10 drained", 0, 0, 0);
    dma_qmap = '0;
  endtask

  task automatic t_bad_addr();
    reg_write(3'd6, 32'hFFFF_FFFF);
    expect_sel("R12 code 6 no event", 0, 0, 0);
    reg_write(3'd7, 32'hFFFF_FFFF);
    expect_sel("R12 code 7 no event", 0, 0, 0);
    ext_evt = '1; tick(); quiet();
    expect_sel("R12 enables unchanged", 0, 0, 0);
  endtask

  initial begin
    t_reset();
    t_enable_gate();
    t_manual();
    t_chain();
    t_qdma();
    t_priority();
    t_hold();
    t_same_cycle();
    t_blocked();
    t_bad_addr();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule